// File: doc/BRIEF.md
# Lock-Step Binary and Gray Counter

A free-running binary up-counter with a companion Gray-code register that changes exactly one bit per count step. The Gray value is not decoded from the counter's register outputs. Delay differences between those bits would pass straight into any decode of them and cause glitches. Instead, the counter's next-state value is encoded to Gray and captured in a register of its own on the same clock edge as the counter. The two registers therefore always hold matching values, with no cycle of lag between them.

A combinational Gray-to-binary decoder reads the registered Gray value back, so the counter value can be recovered from the Gray side alone. Two structures are available for the decoder:

- a ripple chain, which needs the fewest gates;
- a logarithmic-depth XOR scan, which has the shortest path for wide counters.

The counter width is a parameter and defaults to 48 bits. Moving the count across clock domains is left to logic outside this block.

Top module: `gray_lockstep_counter`

## Requirements
- R1: When `rst` is high at a rising clock edge, both `bin_q` and `gray_q` are zero after that edge, whatever the value of `en`.
- R2: When `rst` is low and `en` is high at an edge, `bin_q` becomes its previous value plus one, modulo 2^WIDTH. All ones wraps to zero.
- R3: When `rst` and `en` are both low at an edge, `bin_q` and `gray_q` keep their values.
- R4: After every edge, `gray_q` equals `bin_q ^ (bin_q >> 1)`, where bit i of `gray_q` is bit i of `bin_q` XOR bit i+1 and the top bit is copied unchanged. No cycle lies between the two.
- R5: Across an edge with `en` high and `rst` low, `gray_q` changes in exactly one bit. This includes the wrap from all ones to zero, where only the top bit changes.
- R6: `gray_bin` is the combinational decode of `gray_q`: bit i is the XOR of `gray_q` bits i through WIDTH-1. It therefore equals `bin_q`.
- R7: `WIDTH` (default 48, at least 2) sets all port widths. `DECODE_SCAN` = 0 selects the ripple decoder and 1 selects the logarithmic scan decoder. Both selections give the same `gray_bin`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable, active high |
| bin_q | output | WIDTH | Registered binary count |
| gray_q | output | WIDTH | Registered Gray code of the count |
| gray_bin | output | WIDTH | Binary value decoded from `gray_q` |

## Verification
The hardest case to reach is the wrap from all ones to zero, where every binary bit flips and the Gray side must still move in its top bit alone. At the default width this case is out of reach. The bench therefore runs two small instances, of 4 and 5 bits, one with each decoder structure, and sweeps them through more than a full cycle of their count. It then interleaves enable-low stretches and a reset asserted together with the enable, so that hold and reset priority are both checked in the middle of a count.

// File: rtl/gray_lockstep_pkg.sv
package gray_lockstep_pkg;

   // Number of doubling stages a prefix scan needs over w bits
   function automatic int scan_stages(input int w);
      int s;
      s = 0;
      while ((1 << s) < w) s++;
      return s;
   endfunction

endpackage

// File: rtl/gls_bin2gray.sv
module gls_bin2gray #(
   parameter int WIDTH = 48
) (
   input  logic [WIDTH-1:0] bin_i,
   output logic [WIDTH-1:0] gray_o
);
   // Each Gray bit compares a binary bit with its upper neighbour
   assign gray_o = bin_i ^ (bin_i >> 1);
endmodule

// File: rtl/gls_gray2bin.sv
module gls_gray2bin
   import gray_lockstep_pkg::*;
#(
   parameter int WIDTH       = 48,
   parameter bit DECODE_SCAN = 1'b0
) (
   input  logic [WIDTH-1:0] gray_i,
   output logic [WIDTH-1:0] bin_o
);
   localparam int STAGES = scan_stages(WIDTH);

   generate
      if (DECODE_SCAN == 1'b0) begin : g_ripple
         // Chain from the top bit down; depth grows with WIDTH
         logic [WIDTH-1:0] chain;
         assign chain[WIDTH-1] = gray_i[WIDTH-1];
         for (genvar i = WIDTH - 2; i >= 0; i--) begin : g_bit
            assign chain[i] = chain[i+1] ^ gray_i[i];
         end
         assign bin_o = chain;
      end else begin : g_scan
         // Suffix XOR scan: stage s folds in the bit 2^s positions higher
         logic [WIDTH-1:0] lvl [0:STAGES];
         assign lvl[0] = gray_i;
         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            for (genvar i = 0; i < WIDTH; i++) begin : g_bit
               if (i + (1 << s) < WIDTH) begin : g_fold
                  assign lvl[s+1][i] = lvl[s][i] ^ lvl[s][i + (1 << s)];
               end else begin : g_pass
                  assign lvl[s+1][i] = lvl[s][i];
               end
            end
         end
         assign bin_o = lvl[STAGES];
      end
   endgenerate
endmodule

// File: rtl/gls_count_core.sv
module gls_count_core #(
   parameter int WIDTH = 48
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   output logic [WIDTH-1:0] cnt_q,
   output logic [WIDTH-1:0] cnt_d
);
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   always_comb begin
      if (rst)      cnt_d = '0;
      else if (en)  cnt_d = cnt_q + ONE;
      else          cnt_d = cnt_q;
   end

   always_ff @(posedge clk) cnt_q <= cnt_d;

   // R2: enabled edge adds one, wrapping modulo 2^WIDTH
   a_r2_increment: assert property (@(posedge clk) disable iff (rst)
      en |=> cnt_q == $past(cnt_q) + ONE);

   // R3: disabled edge holds the count
   a_r3_hold_count: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(cnt_q));
endmodule

// File: rtl/gls_gray_reg.sv
module gls_gray_reg #(
   parameter int WIDTH = 48
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [WIDTH-1:0] gray_d,
   output logic [WIDTH-1:0] gray_q
);
   // Loaded every edge from the encoded next count, so it tracks the counter
   always_ff @(posedge clk) gray_q <= gray_d;

   // R5: one Gray bit moves per enabled step, wrap included
   a_r5_single_bit: assert property (@(posedge clk) disable iff (rst)
      en |=> $countones(gray_q ^ $past(gray_q)) == 1);

   // R3: disabled edge holds the Gray value
   a_r3_hold_gray: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(gray_q));
endmodule

// File: rtl/gray_lockstep_counter.sv
module gray_lockstep_counter #(
   parameter int WIDTH       = 48,
   parameter bit DECODE_SCAN = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   output logic [WIDTH-1:0] bin_q,
   output logic [WIDTH-1:0] gray_q,
   output logic [WIDTH-1:0] gray_bin
);
   // R7: width guard at elaboration
   generate
      if (WIDTH < 2) begin : g_bad_width
         initial $error("gray_lockstep_counter: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] cnt_next;
   logic [WIDTH-1:0] gray_next;

   gls_count_core #(.WIDTH(WIDTH)) u_core (
      .clk   (clk),
      .rst   (rst),
      .en    (en),
      .cnt_q (bin_q),
      .cnt_d (cnt_next)
   );

   gls_bin2gray #(.WIDTH(WIDTH)) u_enc (
      .bin_i  (cnt_next),
      .gray_o (gray_next)
   );

   gls_gray_reg #(.WIDTH(WIDTH)) u_greg (
      .clk    (clk),
      .rst    (rst),
      .en     (en),
      .gray_d (gray_next),
      .gray_q (gray_q)
   );

   gls_gray2bin #(.WIDTH(WIDTH), .DECODE_SCAN(DECODE_SCAN)) u_dec (
      .gray_i (gray_q),
      .bin_o  (gray_bin)
   );

   logic rst_seen;
   always_ff @(posedge clk) rst_seen <= rst;

   // R1: an edge with reset leaves both registers at zero
   always @(posedge clk) begin
      if (rst_seen) begin
         a_r1_reset_clears: assert (bin_q == '0 && gray_q == '0);
      end
   end

   // R4: Gray register matches the counter in the same cycle
   a_r4_lockstep: assert property (@(posedge clk) disable iff (rst)
      gray_q == (bin_q ^ (bin_q >> 1)));

   // R6: decoder recovers the count from the Gray register
   a_r6_decode: assert property (@(posedge clk) disable iff (rst)
      gray_bin == bin_q);
endmodule

// File: tb/gray_lockstep_counter_test.sv
module gray_lockstep_counter_test;
   localparam int WA = 4;
   localparam int WB = 5;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en  = 1'b0;
   logic [WA-1:0] bin_a, gray_a, dec_a;
   logic [WB-1:0] bin_b, gray_b, dec_b;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // Reference model state and the previous Gray value of each instance
   int exp_a = 0, exp_b = 0;
   int prev_ga = 0, prev_gb = 0;

   always #4 clk = ~clk;

   gray_lockstep_counter #(.WIDTH(WA), .DECODE_SCAN(1'b1)) uut (
      .clk(clk), .rst(rst), .en(en),
      .bin_q(bin_a), .gray_q(gray_a), .gray_bin(dec_a)
   );

   gray_lockstep_counter #(.WIDTH(WB), .DECODE_SCAN(1'b0)) uut_b (
      .clk(clk), .rst(rst), .en(en),
      .bin_q(bin_b), .gray_q(gray_b), .gray_bin(dec_b)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   function automatic int to_gray(input int v);
      return v ^ (v >> 1);
   endfunction

   function automatic int ones(input int v);
      int n = 0;
      for (int i = 0; i < 32; i++) n += (v >> i) & 1;
      return n;
   endfunction

   // Apply inputs, clock once, update the model, then check at the falling edge
   task automatic tick(input bit r, input bit e);
      rst = r;
      en  = e;
      prev_ga = int'(gray_a);
      prev_gb = int'(gray_b);
      @(posedge clk);
      if (r) begin
         exp_a = 0;
         exp_b = 0;
      end else if (e) begin
         exp_a = (exp_a + 1) % (1 << WA);
         exp_b = (exp_b + 1) % (1 << WB);
      end
      @(negedge clk);
      if (r) begin
         chk(bin_a == 0 && gray_a == 0, "R1 reset width4", int'(bin_a), 0);
         chk(bin_b == 0 && gray_b == 0, "R1 reset width5", int'(bin_b), 0);
      end else begin
         if (e) begin
            chk(int'(bin_a) == exp_a, "R2 count width4", int'(bin_a), exp_a);
            chk(int'(bin_b) == exp_b, "R2 count width5", int'(bin_b), exp_b);
            chk(ones(int'(gray_a) ^ prev_ga) == 1, "R5 one-bit step width4",
                int'(gray_a), prev_ga);
            chk(ones(int'(gray_b) ^ prev_gb) == 1, "R5 one-bit step width5",
                int'(gray_b), prev_gb);
         end else begin
            chk(int'(bin_a) == exp_a && int'(gray_a) == prev_ga, "R3 hold width4",
                int'(bin_a), exp_a);
            chk(int'(bin_b) == exp_b && int'(gray_b) == prev_gb, "R3 hold width5",
                int'(bin_b), exp_b);
         end
         chk(int'(gray_a) == to_gray(exp_a), "R4 gray width4", int'(gray_a), to_gray(exp_a));
         chk(int'(gray_b) == to_gray(exp_b), "R4 gray width5", int'(gray_b), to_gray(exp_b));
         chk(int'(dec_a) == exp_a, "R6 R7 scan decode width4", int'(dec_a), exp_a);
         chk(int'(dec_b) == exp_b, "R6 R7 ripple decode width5", int'(dec_b), exp_b);
      end
   endtask

   initial begin
      @(negedge clk);
      // R1: reset with the enable high still clears
      tick(1'b1, 1'b1);
      tick(1'b1, 1'b0);
      // R2 R5: full sweep past both wrap points
      for (int k = 0; k < (1 << WB) + 6; k++) tick(1'b0, 1'b1);
      // R3: hold stretch
      for (int k = 0; k < 4; k++) tick(1'b0, 1'b0);
      // Interleaved enable pattern
      for (int k = 0; k < 40; k++) tick(1'b0, (k % 3) != 1);
      // R1: reset in mid-count with the enable high, then resume
      tick(1'b1, 1'b1);
      for (int k = 0; k < 20; k++) tick(1'b0, 1'b1);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule